// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block sits between the decode stage and the architectural state of a pipeline whose execution units finish out of order. Decode claims a slot at the tail of a circular buffer and gets the slot number back as the instruction's tag. When an execution unit finishes, it writes its result, an address and an exception flag into the slot named by that tag. Nothing reaches the register file or the store path at that point.

Only the oldest slot may leave the buffer, and only after its result has been recorded. The block then drives a register write or a store for it, at most one per cycle. If the oldest finished slot carries an exception flag, nothing is committed. The block raises an exception pulse carrying that instruction's PC and discards it and every younger slot. Every older instruction has then been committed and no younger one has. A separate read port lets a later instruction look up a pending result by tag.

Top module: `rob_inorder`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `ret_reg_we`, `ret_st_we` and `exc_valid` are 0.
- R2: Each accepted allocation (`alloc_req` with `alloc_ready` high) returns on `alloc_tag` the current tail slot number. Successive tags count up by one and wrap from 15 to 0.
- R3: A completion (`cmp_valid`) stores `cmp_value` and `cmp_addr` into the slot `cmp_tag`. From the next cycle, the read port with `rd_tag` set to that slot shows `rd_done`=1 and `rd_value`=`cmp_value`.
- R4: A slot commits only when it is the oldest and complete. Younger slots that complete earlier wait, and commits happen in allocation order.
- R5: At most one slot commits per cycle. A committing slot that has a destination drives `ret_reg_we` with its destination ID and value. A committing store drives `ret_st_we` with `cmp_addr` as the address and `cmp_value` as the data. A store does not write the register file.
- R6: With 16 slots occupied, `alloc_ready` is 0 and an `alloc_req` is ignored. No extra slot is created, so exactly the 16 held instructions later commit.
- R7: When the oldest slot is complete with its exception flag set, `exc_valid` is 1 for one cycle with that slot's PC on `exc_pc`. No slot commits in that cycle. All slots are then discarded, and the next tag handed out equals the faulting slot's tag.
- R8: A completion aimed at a slot that is not allocated is ignored: the read port shows `rd_done`=0 for that slot.
- R9: The read port shows `rd_done`=0 for an allocated slot whose result has not yet been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Decode requests a slot |
| alloc_dest | input | 5 | Destination register ID |
| alloc_has_dest | input | 1 | Instruction writes a register |
| alloc_is_store | input | 1 | Instruction is a store |
| alloc_pc | input | 32 | Instruction PC |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | 4 | Tag of the slot being handed out |
| cmp_valid | input | 1 | An execution unit reports a result |
| cmp_tag | input | 4 | Slot the result belongs to |
| cmp_value | input | 32 | Result value or store data |
| cmp_addr | input | 32 | Store address or branch target |
| cmp_exc | input | 1 | The instruction raised an exception |
| ret_reg_we | output | 1 | Register file write from the oldest slot |
| ret_reg_id | output | 5 | Register written |
| ret_reg_value | output | 32 | Value written |
| ret_st_we | output | 1 | Store commit from the oldest slot |
| ret_st_addr | output | 32 | Store address |
| ret_st_data | output | 32 | Store data |
| exc_valid | output | 1 | Precise exception taken |
| exc_pc | output | 32 | PC of the faulting instruction |
| rd_tag | input | 4 | Slot looked up by the read port |
| rd_done | output | 1 | Looked-up slot holds a result |
| rd_value | output | 32 | Looked-up result |

## Verification
Completions are driven newest-first and in allocation order. Newest-first shows whether commit waits on the oldest slot or lets finished younger ones leave early. In-order completion shows that commits follow one per cycle without gaps. A run of sixteen allocations crosses the wrap of the tag counter and fills the buffer, which separates a correct full test from an off-by-one that admits a seventeenth slot. An exception on the oldest slot, after its two younger neighbours have already completed, shows whether the flush truly drops finished work. A completion sent to an unallocated slot shows whether stray writes are filtered.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 16;
    localparam int AREG_W    = 5;
    localparam int XLEN      = 32;

    typedef struct packed {
        logic              done;
        logic              exc;
        logic              has_dest;
        logic              is_store;
        logic [AREG_W-1:0] dest;
        logic [XLEN-1:0]   value;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   pc;
    } rob_entry_t;

    function automatic int idx_bits(input int depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic             retire,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             empty,
    output logic             full,
    output logic [IDX_W:0]   count
);
    logic [IDX_W:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (flush)
                tail_q <= head_q;
            else if (alloc_fire)
                tail_q <= tail_q + 1'b1;
            if (retire)
                head_q <= head_q + 1'b1;
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                      (head_q[IDX_W] != tail_q[IDX_W]);
    assign count    = tail_q - head_q;

    // R6: occupancy never exceeds the slot count
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= (IDX_W+1)'(DEPTH));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_we,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              alloc_has_dest,
    input  logic              alloc_is_store,
    input  logic [XLEN-1:0]   alloc_pc,
    input  logic              cmp_we,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [XLEN-1:0]   cmp_value,
    input  logic [XLEN-1:0]   cmp_addr,
    input  logic              cmp_exc,
    input  logic              clr_we,
    input  logic              flush,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output rob_entry_t        head_ent,
    output logic              head_valid,
    output logic              rd_done,
    output logic [XLEN-1:0]   rd_value,
    output logic [DEPTH-1:0]  valid_vec
);
    rob_entry_t ent_q   [DEPTH];
    logic       valid_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
                ent_q[i]   <= '0;
            end else if (flush) begin
                valid_q[i] <= 1'b0;
            end else if (alloc_we && alloc_idx == IDX_W'(i)) begin
                valid_q[i]        <= 1'b1;
                ent_q[i].done     <= 1'b0;
                ent_q[i].exc      <= 1'b0;
                ent_q[i].has_dest <= alloc_has_dest;
                ent_q[i].is_store <= alloc_is_store;
                ent_q[i].dest     <= alloc_dest;
                ent_q[i].pc       <= alloc_pc;
            end else if (cmp_we && cmp_idx == IDX_W'(i) && valid_q[i]) begin
                ent_q[i].done  <= 1'b1;
                ent_q[i].exc   <= cmp_exc;
                ent_q[i].value <= cmp_value;
                ent_q[i].addr  <= cmp_addr;
            end else if (clr_we && head_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++)
            valid_vec[k] = valid_q[k];
    end

    assign head_ent   = ent_q[head_idx];
    assign head_valid = valid_q[head_idx];
    assign rd_done    = valid_q[rd_idx] && ent_q[rd_idx].done;
    assign rd_value   = ent_q[rd_idx].value;
endmodule

// File: rtl/rob_commit.sv
module rob_commit
    import rob_pkg::*;
(
    input  logic              empty,
    input  logic              head_valid,
    input  rob_entry_t        head_ent,
    output logic              retire,
    output logic              flush,
    output logic              ret_reg_we,
    output logic [AREG_W-1:0] ret_reg_id,
    output logic [XLEN-1:0]   ret_reg_value,
    output logic              ret_st_we,
    output logic [XLEN-1:0]   ret_st_addr,
    output logic [XLEN-1:0]   ret_st_data,
    output logic [XLEN-1:0]   exc_pc
);
    logic head_ready;

    assign head_ready    = !empty && head_valid && head_ent.done;
    assign retire        = head_ready && !head_ent.exc;
    assign flush         = head_ready && head_ent.exc;
    assign ret_reg_we    = retire && head_ent.has_dest;
    assign ret_reg_id    = head_ent.dest;
    assign ret_reg_value = head_ent.value;
    assign ret_st_we     = retire && head_ent.is_store;
    assign ret_st_addr   = head_ent.addr;
    assign ret_st_data   = head_ent.value;
    assign exc_pc        = head_ent.pc;
endmodule

// File: rtl/rob_inorder.sv
module rob_inorder
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              alloc_has_dest,
    input  logic              alloc_is_store,
    input  logic [XLEN-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_tag,
    input  logic [XLEN-1:0]   cmp_value,
    input  logic [XLEN-1:0]   cmp_addr,
    input  logic              cmp_exc,
    output logic              ret_reg_we,
    output logic [AREG_W-1:0] ret_reg_id,
    output logic [XLEN-1:0]   ret_reg_value,
    output logic              ret_st_we,
    output logic [XLEN-1:0]   ret_st_addr,
    output logic [XLEN-1:0]   ret_st_data,
    output logic              exc_valid,
    output logic [XLEN-1:0]   exc_pc,
    input  logic [IDX_W-1:0]  rd_tag,
    output logic              rd_done,
    output logic [XLEN-1:0]   rd_value
);
    logic             retire, flush, empty, full, alloc_fire, head_valid;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [IDX_W:0]   count;
    logic [DEPTH-1:0] valid_vec;
    rob_entry_t       head_ent;

    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_req && alloc_ready;
    assign alloc_tag   = tail_idx;
    assign exc_valid   = flush;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .retire(retire),
        .flush(flush), .head_idx(head_idx), .tail_idx(tail_idx),
        .empty(empty), .full(full), .count(count)
    );

    rob_entry_array #(.DEPTH(DEPTH)) u_arr (
        .clk(clk), .rst(rst),
        .alloc_we(alloc_fire), .alloc_idx(tail_idx), .alloc_dest(alloc_dest),
        .alloc_has_dest(alloc_has_dest), .alloc_is_store(alloc_is_store),
        .alloc_pc(alloc_pc),
        .cmp_we(cmp_valid), .cmp_idx(cmp_tag), .cmp_value(cmp_value),
        .cmp_addr(cmp_addr), .cmp_exc(cmp_exc),
        .clr_we(retire), .flush(flush), .head_idx(head_idx), .rd_idx(rd_tag),
        .head_ent(head_ent), .head_valid(head_valid),
        .rd_done(rd_done), .rd_value(rd_value), .valid_vec(valid_vec)
    );

    rob_commit u_cmt (
        .empty(empty), .head_valid(head_valid), .head_ent(head_ent),
        .retire(retire), .flush(flush),
        .ret_reg_we(ret_reg_we), .ret_reg_id(ret_reg_id),
        .ret_reg_value(ret_reg_value), .ret_st_we(ret_st_we),
        .ret_st_addr(ret_st_addr), .ret_st_data(ret_st_data), .exc_pc(exc_pc)
    );

    // R1: an empty buffer commits nothing and raises nothing
    a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !(ret_reg_we || ret_st_we || exc_valid));

    // R4: a result being written into the oldest slot cannot commit that cycle
    a_r4_commit_after_record: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_tag == head_idx) |-> !retire);

    // R5: commit and exception never share a cycle
    a_r5_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ret_reg_we || ret_st_we, exc_valid}));

    // R6: a full buffer refuses allocation
    a_r6_full_stall: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ready);

    // R6: live slot flags agree with the pointer distance
    a_r6_occupancy: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_vec) == int'(count));

    // R7: an exception leaves the buffer empty
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (count == '0));
endmodule

// File: tb/tb_rob_inorder.sv
module tb_rob_inorder;
    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_req, alloc_has_dest, alloc_is_store;
    logic [4:0]  alloc_dest;
    logic [31:0] alloc_pc;
    logic        alloc_ready;
    logic [3:0]  alloc_tag;
    logic        cmp_valid, cmp_exc;
    logic [3:0]  cmp_tag;
    logic [31:0] cmp_value, cmp_addr;
    logic        ret_reg_we, ret_st_we, exc_valid;
    logic [4:0]  ret_reg_id;
    logic [31:0] ret_reg_value, ret_st_addr, ret_st_data, exc_pc;
    logic [3:0]  rd_tag;
    logic        rd_done;
    logic [31:0] rd_value;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_ret = 0, n_st = 0, n_exc = 0;
    logic [4:0]  ret_dest [64];
    logic [31:0] ret_val  [64];
    int          ret_cyc  [64];
    logic [31:0] st_addr_log, st_data_log, exc_pc_log;

    always #5 clk = ~clk;

    rob_inorder dut (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_dest(alloc_dest),
        .alloc_has_dest(alloc_has_dest), .alloc_is_store(alloc_is_store),
        .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_addr(cmp_addr), .cmp_exc(cmp_exc),
        .ret_reg_we(ret_reg_we), .ret_reg_id(ret_reg_id),
        .ret_reg_value(ret_reg_value), .ret_st_we(ret_st_we),
        .ret_st_addr(ret_st_addr), .ret_st_data(ret_st_data),
        .exc_valid(exc_valid), .exc_pc(exc_pc),
        .rd_tag(rd_tag), .rd_done(rd_done), .rd_value(rd_value)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // commit monitor, sampled between edges
    always @(negedge clk) begin
        if (!rst) begin
            if (ret_reg_we && n_ret < 64) begin
                ret_dest[n_ret] = ret_reg_id;
                ret_val[n_ret]  = ret_reg_value;
                ret_cyc[n_ret]  = cyc;
                n_ret++;
            end
            if (ret_st_we) begin
                st_addr_log = ret_st_addr;
                st_data_log = ret_st_data;
                n_st++;
            end
            if (exc_valid) begin
                exc_pc_log = exc_pc;
                n_exc++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_alloc(input logic [4:0] dest, input logic has_d,
                            input logic is_st, input logic [31:0] pc,
                            output logic [3:0] tag);
        alloc_req = 1'b1; alloc_dest = dest; alloc_has_dest = has_d;
        alloc_is_store = is_st; alloc_pc = pc;
        @(negedge clk);
        tag = alloc_tag;
        @(posedge clk); #1;
        alloc_req = 1'b0;
    endtask

    task automatic do_cmp(input logic [3:0] tag, input logic [31:0] val,
                          input logic [31:0] addr, input logic exc);
        cmp_valid = 1'b1; cmp_tag = tag; cmp_value = val;
        cmp_addr = addr; cmp_exc = exc;
        @(posedge clk); #1;
        cmp_valid = 1'b0; cmp_exc = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R1 alloc_ready", 32'(alloc_ready), 1);
        chk(alloc_tag == 4'd0, "R1 alloc_tag", 32'(alloc_tag), 0);
        chk(!ret_reg_we && !ret_st_we && !exc_valid, "R1 outputs idle",
            32'({ret_reg_we, ret_st_we, exc_valid}), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_in_order();
        logic [3:0] t0, t1, t2;
        do_alloc(5'd3, 1'b1, 1'b0, 32'h100, t0);
        do_alloc(5'd4, 1'b1, 1'b0, 32'h104, t1);
        do_alloc(5'd5, 1'b1, 1'b0, 32'h108, t2);
        chk(t2 == 4'd2, "R2 third tag", 32'(t2), 2);
        do_cmp(t2, 32'hA2, 32'h0, 1'b0);
        do_cmp(t1, 32'hA1, 32'h0, 1'b0);
        idle(2);
        @(negedge clk);
        chk(n_ret == 0, "R4 younger waits", 32'(n_ret), 0);
        rd_tag = t2; #1;
        chk(rd_done == 1'b1, "R3 read done", 32'(rd_done), 1);
        chk(rd_value == 32'hA2, "R3 read value", rd_value, 32'hA2);
        rd_tag = t0; #1;
        chk(rd_done == 1'b0, "R9 pending not done", 32'(rd_done), 0);
        @(posedge clk); #1;
        do_cmp(t0, 32'hA0, 32'h0, 1'b0);
        idle(5);
        chk(n_ret == 3, "R4 all committed", 32'(n_ret), 3);
        chk(ret_dest[0] == 5'd3 && ret_dest[2] == 5'd5, "R4 order dest",
            32'({ret_dest[0], ret_dest[2]}), 32'({5'd3, 5'd5}));
        chk(ret_val[0] == 32'hA0 && ret_val[1] == 32'hA1 && ret_val[2] == 32'hA2,
            "R5 values", ret_val[1], 32'hA1);
        chk(ret_cyc[1] == ret_cyc[0] + 1 && ret_cyc[2] == ret_cyc[1] + 1,
            "R5 one per cycle", 32'(ret_cyc[2] - ret_cyc[0]), 2);
    endtask

    task automatic t_store();
        logic [3:0] t;
        do_alloc(5'd9, 1'b0, 1'b1, 32'h10C, t);
        do_cmp(t, 32'hD5, 32'h400, 1'b0);
        idle(3);
        chk(n_st == 1, "R5 store count", 32'(n_st), 1);
        chk(st_addr_log == 32'h400, "R5 store addr", st_addr_log, 32'h400);
        chk(st_data_log == 32'hD5, "R5 store data", st_data_log, 32'hD5);
        chk(n_ret == 3, "R5 store no reg write", 32'(n_ret), 3);
    endtask

    task automatic t_full();
        logic [3:0] t;
        int bad_tags = 0;
        for (int i = 0; i < 16; i++) begin
            do_alloc(5'(i % 8 + 1), 1'b1, 1'b0, 32'h300 + 32'(i), t);
            if (t != 4'((4 + i) % 16)) bad_tags++;
        end
        chk(bad_tags == 0, "R2 wrapping tags", 32'(bad_tags), 0);
        @(negedge clk);
        chk(alloc_ready == 1'b0, "R6 full blocks", 32'(alloc_ready), 0);
        @(posedge clk); #1;
        alloc_req = 1'b1; alloc_dest = 5'd31; alloc_has_dest = 1'b1;
        @(posedge clk); #1;
        alloc_req = 1'b0;
        for (int i = 0; i < 16; i++)
            do_cmp(4'((4 + i) % 16), 32'h100 + 32'(i), 32'h0, 1'b0);
        idle(20);
        chk(n_ret == 19, "R6 exactly sixteen commit", 32'(n_ret), 19);
        chk(ret_val[18] == 32'h10F, "R6 last value", ret_val[18], 32'h10F);
    endtask

    task automatic t_exception();
        logic [3:0] ta, tb, tc;
        do_alloc(5'd6, 1'b1, 1'b0, 32'h200, ta);
        do_alloc(5'd7, 1'b1, 1'b0, 32'h204, tb);
        do_alloc(5'd8, 1'b1, 1'b0, 32'h208, tc);
        do_cmp(tc, 32'hC3, 32'h0, 1'b0);
        do_cmp(tb, 32'hB2, 32'h0, 1'b0);
        do_cmp(ta, 32'hE1, 32'h0, 1'b1);
        idle(3);
        chk(n_exc == 1, "R7 single pulse", 32'(n_exc), 1);
        chk(exc_pc_log == 32'h200, "R7 exc pc", exc_pc_log, 32'h200);
        chk(n_ret == 19, "R7 younger dropped", 32'(n_ret), 19);
        @(negedge clk);
        chk(alloc_tag == ta, "R7 tail reset to head", 32'(alloc_tag), 32'(ta));
        rd_tag = tb; #1;
        chk(rd_done == 1'b0, "R7 flushed slot gone", 32'(rd_done), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_stray();
        do_cmp(4'd9, 32'h55, 32'h0, 1'b0);
        idle(1);
        @(negedge clk);
        rd_tag = 4'd9; #1;
        chk(rd_done == 1'b0, "R8 stray ignored", 32'(rd_done), 0);
        chk(n_ret == 19 && n_exc == 1, "R8 no commit", 32'(n_ret), 19);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; alloc_req = 1'b0; alloc_dest = '0; alloc_has_dest = 1'b0;
        alloc_is_store = 1'b0; alloc_pc = '0; cmp_valid = 1'b0; cmp_tag = '0;
        cmp_value = '0; cmp_addr = '0; cmp_exc = 1'b0; rd_tag = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_in_order();
        t_store();
        t_full();
        t_exception();
        t_stray();
        finish_run();
    end
endmodule